// File: doc/BRIEF.md
# Flash Bus Command Sequence Decoder

This block sits behind the byte-wide asynchronous write port of a parallel flash device. It turns bus write cycles into device commands. The write strobe is brought into the system clock domain and edge-detected. The address is captured when the strobe falls and the data when it rises. Only cycles with chip enable low and output enable high count as writes.

The decoder follows the multi-write unlock sequences. When a sequence completes, it raises a one-cycle command pulse to the embedded-operation controller. The pulse carries an opcode and, where the command needs them, the captured address and data. A wrong address, wrong data or a step out of order drops the decoder back to plain read mode without a command. The controller reports back whether a program is running, whether a sector erase is running, and whether an erase is suspended. These inputs gate which writes are honoured.

After the identify sequence, the decoder marks identify mode. While that mode is set, it supplies the byte a read must return: the manufacturer code, the device code, or the protect status of the addressed sector.

The command output is a plain pulse with no ready. The controller must take every pulse in the cycle it is raised. At most one pulse can occur per bus write, so pulses are always many clocks apart.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `cmd_valid` is 0 and `id_mode` is 0, and the decoder is in read mode.
- R2: Outside the program data step, one write of F0h at any address raises `cmd_valid` for one cycle with `cmd_op`=0 (reset) and returns to read mode. This also clears identify mode. The `cmd_op` codes are: 0 reset, 1 identify, 2 program, 3 chip erase, 4 sector erase, 5 erase suspend, 6 erase resume.
- R3: Unlock steps compare only address bits [10:0] against 555h or 2AAh. Bits above bit 10 do not affect the match.
- R4: Writing AAh@555h, then 55h@2AAh, then 90h@555h issues opcode 1 and sets `id_mode`.
- R5: While `id_mode` is 1, `id_rdata` depends on `bus_addr[1:0]`: 00 gives MFR_CODE (C2h), 01 gives DEV_CODE, 10 gives 01h if `sect_prot` is 1 and 00h otherwise, and 11 gives 00h. While `id_mode` is 0, `id_rdata` is 00h.
- R6: Writing AAh@555h, then 55h@2AAh, then A0h@555h, then any byte at any address issues opcode 2. `cmd_addr` carries the full address of the fourth write and `cmd_data` carries its byte.
- R7: Writing AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, then 10h@555h issues opcode 3.
- R8: The same first five writes followed by 30h at any address issue opcode 4, with `cmd_addr` holding that address.
- R9: A write whose address or data does not fit the next step aborts the sequence with no command. Later steps of the aborted sequence then issue nothing.
- R10: With no erase running or suspended, single writes of B0h and of 30h issue nothing. A single 30h write while `ctl_erase_susp` is 1 issues opcode 6.
- R11: While `ctl_prog_busy` is 1, every write is ignored: no command is issued and the mode does not change.
- R12: While `ctl_erase_busy` is 1, a B0h write issues opcode 5. Every other write, F0h included, is ignored.
- R13: A strobe pulse while `bus_ce_n` is 1, or while `bus_oe_n` is 0, is not treated as a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_ce_n | input | 1 | Chip enable, active low |
| bus_we_n | input | 1 | Write strobe, active low, asynchronous |
| bus_oe_n | input | 1 | Output enable, active low |
| bus_addr | input | ADDR_W | Bus address |
| bus_din | input | 8 | Bus write data |
| ctl_prog_busy | input | 1 | Controller is programming |
| ctl_erase_busy | input | 1 | Controller is running a sector erase |
| ctl_erase_susp | input | 1 | Sector erase is suspended |
| sect_prot | input | 1 | Protect status of the addressed sector |
| cmd_valid | output | 1 | One-cycle command pulse |
| cmd_op | output | 3 | Command opcode |
| cmd_addr | output | ADDR_W | Captured address for the command |
| cmd_data | output | 8 | Captured data for the command |
| id_mode | output | 1 | Identify mode active |
| id_rdata | output | 8 | Byte to return on a read in identify mode |

## Verification
The bench builds the decoder with an 18-bit address and a two-stage strobe synchroniser. It overrides DEV_CODE to 34h, so that the identify read of the device code can be told apart from the default. Because the address is wider than the 11-bit unlock field, the bench can set the upper bits during unlock writes and show that they are ignored. The same width lets the program and sector erase checks carry addresses high in the space.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  typedef enum logic [2:0] {
    OP_RESET   = 3'd0,
    OP_IDENT   = 3'd1,
    OP_PROGRAM = 3'd2,
    OP_CHIP_ER = 3'd3,
    OP_SECT_ER = 3'd4,
    OP_SUSPEND = 3'd5,
    OP_RESUME  = 3'd6
  } fcd_op_e;

  typedef enum logic [2:0] {
    ST_READ,
    ST_UNL1,
    ST_UNL2,
    ST_PGM,
    ST_ER3,
    ST_ER4,
    ST_ER5,
    ST_IDENT
  } fcd_state_e;

  localparam logic [7:0] D_KEY1   = 8'hAA;
  localparam logic [7:0] D_KEY2   = 8'h55;
  localparam logic [7:0] D_RESET  = 8'hF0;
  localparam logic [7:0] D_IDENT  = 8'h90;
  localparam logic [7:0] D_PGM    = 8'hA0;
  localparam logic [7:0] D_ERASE  = 8'h80;
  localparam logic [7:0] D_CHIP   = 8'h10;
  localparam logic [7:0] D_SECT   = 8'h30;
  localparam logic [7:0] D_SUSP   = 8'hB0;

endpackage

// File: rtl/fcd_wr_sampler.sv
module fcd_wr_sampler #(
  parameter int ADDR_W = 18,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_ce_n,
  input  logic              bus_we_n,
  input  logic              bus_oe_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_din,
  output logic              wr_pulse,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data
);

  logic [SYNC_N-1:0] we_sh;
  logic              we_s;
  logic              we_d;
  logic              armed;
  logic              fall;
  logic              rise;

  assign we_s = we_sh[SYNC_N-1];
  assign fall = we_d & ~we_s;
  assign rise = ~we_d & we_s;

  // strobe synchroniser chain
  always_ff @(posedge clk) begin
    if (!rst_n) we_sh <= '1;
    else        we_sh <= {we_sh[SYNC_N-2:0], bus_we_n};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      we_d     <= 1'b1;
      armed    <= 1'b0;
      wr_pulse <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      we_d     <= we_s;
      wr_pulse <= 1'b0;
      if (fall) begin
        armed   <= !bus_ce_n && bus_oe_n;
        wr_addr <= bus_addr;
      end
      if (rise && armed) begin
        wr_pulse <= 1'b1;
        wr_data  <= bus_din;
        armed    <= 1'b0;
      end
    end
  end

  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |=> !wr_pulse); // R13
  AST_WR_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |-> $past(armed)); // R13

endmodule

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int UNLK_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_pulse,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              ctl_prog_busy,
  input  logic              ctl_erase_busy,
  input  logic              ctl_erase_susp,
  output logic              cmd_valid,
  output fcd_op_e           cmd_op,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [7:0]        cmd_data,
  output logic              id_mode
);

  localparam logic [UNLK_W-1:0] A_FIRST  = UNLK_W'(11'h555);
  localparam logic [UNLK_W-1:0] A_SECOND = UNLK_W'(11'h2AA);

  fcd_state_e st, st_nx;
  logic       issue;
  fcd_op_e    op_nx;
  logic       at_first, at_second;

  assign at_first  = wr_addr[UNLK_W-1:0] == A_FIRST;
  assign at_second = wr_addr[UNLK_W-1:0] == A_SECOND;

  always_comb begin
    st_nx = st;
    issue = 1'b0;
    op_nx = OP_RESET;
    if (wr_pulse) begin
      if (ctl_prog_busy) begin
        st_nx = st;
      end else if (ctl_erase_busy) begin
        if (wr_data == D_SUSP) begin
          issue = 1'b1;
          op_nx = OP_SUSPEND;
        end
      end else if (st == ST_PGM) begin
        issue = 1'b1;
        op_nx = OP_PROGRAM;
        st_nx = ST_READ;
      end else if (wr_data == D_RESET) begin
        issue = 1'b1;
        op_nx = OP_RESET;
        st_nx = ST_READ;
      end else begin
        st_nx = ST_READ;
        unique case (st)
          ST_READ, ST_IDENT: begin
            if (at_first && wr_data == D_KEY1) st_nx = ST_UNL1;
            else if (wr_data == D_SECT && ctl_erase_susp) begin
              issue = 1'b1;
              op_nx = OP_RESUME;
            end
          end
          ST_UNL1: if (at_second && wr_data == D_KEY2) st_nx = ST_UNL2;
          ST_UNL2: begin
            if (at_first && wr_data == D_PGM) st_nx = ST_PGM;
            else if (at_first && wr_data == D_ERASE) st_nx = ST_ER3;
            else if (at_first && wr_data == D_IDENT) begin
              st_nx = ST_IDENT;
              issue = 1'b1;
              op_nx = OP_IDENT;
            end
          end
          ST_ER3: if (at_first && wr_data == D_KEY1) st_nx = ST_ER4;
          ST_ER4: if (at_second && wr_data == D_KEY2) st_nx = ST_ER5;
          ST_ER5: begin
            if (at_first && wr_data == D_CHIP) begin
              issue = 1'b1;
              op_nx = OP_CHIP_ER;
            end else if (wr_data == D_SECT) begin
              issue = 1'b1;
              op_nx = OP_SECT_ER;
            end
          end
          default: st_nx = ST_READ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_READ;
      cmd_valid <= 1'b0;
      cmd_op    <= OP_RESET;
      cmd_addr  <= '0;
      cmd_data  <= '0;
    end else begin
      st        <= st_nx;
      cmd_valid <= issue;
      if (issue) begin
        cmd_op   <= op_nx;
        cmd_addr <= wr_addr;
        cmd_data <= wr_data;
      end
    end
  end

  assign id_mode = (st == ST_IDENT);

  AST_PROG_BUSY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pulse && ctl_prog_busy) |=> !cmd_valid); // R11
  AST_ERASE_ONLY_SUSPEND: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pulse && ctl_erase_busy && !ctl_prog_busy) |=> (!cmd_valid || cmd_op == OP_SUSPEND)); // R12
  AST_PGM_AFTER_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_PROGRAM) |-> $past(st) == ST_PGM); // R6
  AST_RESUME_WHEN_SUSP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_RESUME) |-> $past(ctl_erase_susp)); // R10
  AST_ID_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(id_mode) |-> $past(wr_pulse && wr_data == D_IDENT)); // R4

endmodule

// File: rtl/fcd_id_read.sv
module fcd_id_read #(
  parameter logic [7:0] MFR_CODE = 8'hC2,
  parameter logic [7:0] DEV_CODE = 8'hB0
) (
  input  logic       id_mode,
  input  logic [1:0] rd_lo,
  input  logic       sect_prot,
  output logic [7:0] id_rdata
);

  always_comb begin
    id_rdata = 8'h00;
    if (id_mode) begin
      unique case (rd_lo)
        2'b00: id_rdata = MFR_CODE;
        2'b01: id_rdata = DEV_CODE;
        2'b10: id_rdata = {7'b0, sect_prot};
        default: id_rdata = 8'h00;
      endcase
    end
  end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int         ADDR_W   = 18,
  parameter int         UNLK_W   = 11,
  parameter int         SYNC_N   = 2,
  parameter logic [7:0] MFR_CODE = 8'hC2,
  parameter logic [7:0] DEV_CODE = 8'hB0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_ce_n,
  input  logic              bus_we_n,
  input  logic              bus_oe_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_din,
  input  logic              ctl_prog_busy,
  input  logic              ctl_erase_busy,
  input  logic              ctl_erase_susp,
  input  logic              sect_prot,
  output logic              cmd_valid,
  output logic [2:0]        cmd_op,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [7:0]        cmd_data,
  output logic              id_mode,
  output logic [7:0]        id_rdata
);

  logic              wr_pulse;
  logic [ADDR_W-1:0] wr_addr;
  logic [7:0]        wr_data;
  fcd_pkg::fcd_op_e  op_e;

  fcd_wr_sampler #(.ADDR_W(ADDR_W), .SYNC_N(SYNC_N)) u_smp (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_ce_n (bus_ce_n),
    .bus_we_n (bus_we_n),
    .bus_oe_n (bus_oe_n),
    .bus_addr (bus_addr),
    .bus_din  (bus_din),
    .wr_pulse (wr_pulse),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data)
  );

  fcd_seq_fsm #(.ADDR_W(ADDR_W), .UNLK_W(UNLK_W)) u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_pulse       (wr_pulse),
    .wr_addr        (wr_addr),
    .wr_data        (wr_data),
    .ctl_prog_busy  (ctl_prog_busy),
    .ctl_erase_busy (ctl_erase_busy),
    .ctl_erase_susp (ctl_erase_susp),
    .cmd_valid      (cmd_valid),
    .cmd_op         (op_e),
    .cmd_addr       (cmd_addr),
    .cmd_data       (cmd_data),
    .id_mode        (id_mode)
  );

  assign cmd_op = op_e;

  fcd_id_read #(.MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_idr (
    .id_mode   (id_mode),
    .rd_lo     (bus_addr[1:0]),
    .sect_prot (sect_prot),
    .id_rdata  (id_rdata)
  );

  AST_CMD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid); // R2
  AST_ID_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !id_mode |-> id_rdata == 8'h00); // R5

endmodule

// File: tb/flash_cmd_decoder_bench.sv
module flash_cmd_decoder_bench;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 18;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_ce_n = 1'b1, bus_we_n = 1'b1, bus_oe_n = 1'b1;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [7:0]        bus_din = '0;
  logic              ctl_prog_busy = 1'b0, ctl_erase_busy = 1'b0, ctl_erase_susp = 1'b0;
  logic              sect_prot = 1'b0;
  logic              cmd_valid;
  logic [2:0]        cmd_op;
  logic [ADDR_W-1:0] cmd_addr;
  logic [7:0]        cmd_data;
  logic              id_mode;
  logic [7:0]        id_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct packed {
    logic [2:0]        op;
    logic              full;
    logic [ADDR_W-1:0] a;
    logic [7:0]        d;
  } exp_t;
  exp_t q[$];
  string q_tag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_decoder #(.ADDR_W(ADDR_W), .UNLK_W(11), .SYNC_N(2), .DEV_CODE(8'h34)) u_flash_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .bus_ce_n(bus_ce_n), .bus_we_n(bus_we_n), .bus_oe_n(bus_oe_n),
    .bus_addr(bus_addr), .bus_din(bus_din), .ctl_prog_busy(ctl_prog_busy),
    .ctl_erase_busy(ctl_erase_busy), .ctl_erase_susp(ctl_erase_susp), .sect_prot(sect_prot),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .id_mode(id_mode), .id_rdata(id_rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic expect_cmd(input string req, input logic [2:0] op, input logic full,
                            input logic [ADDR_W-1:0] a, input logic [7:0] d);
    q.push_back('{op: op, full: full, a: a, d: d});
    q_tag.push_back(req);
  endtask

  // monitor: pop and compare on each command pulse
  always @(negedge clk) begin
    if (rst_n && cmd_valid) begin
      checks++;
      if (q.size() == 0) begin
        errors++;
        $display("FAIL unexpected command actual=%0d expected=none", cmd_op);
      end else begin
        exp_t e;
        string t;
        e = q.pop_front();
        t = q_tag.pop_front();
        if (cmd_op !== e.op || (e.full && (cmd_addr !== e.a || cmd_data !== e.d))) begin
          errors++;
          $display("FAIL %s actual=%0d/%0h/%0h expected=%0d/%0h/%0h",
                   t, cmd_op, cmd_addr, cmd_data, e.op, e.a, e.d);
        end
      end
    end
  end

  task automatic bus_wr(input logic [ADDR_W-1:0] a, input logic [7:0] d,
                        input logic ce = 1'b0, input logic oe = 1'b1);
    @(negedge clk);
    bus_addr = a; bus_din = d; bus_ce_n = ce; bus_oe_n = oe;
    @(negedge clk);
    bus_we_n = 1'b0;
    repeat (4) @(negedge clk);
    bus_we_n = 1'b1;
    repeat (6) @(negedge clk);
    bus_ce_n = 1'b1; bus_oe_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic drained(input string req);
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL %s actual=%0d pending expected=0", req, q.size());
      q.delete(); q_tag.delete();
    end
  endtask

  task automatic unlock2(input logic [ADDR_W-1:0] hi = '0);
    bus_wr(hi | 18'h555, 8'hAA);
    bus_wr(hi | 18'h2AA, 8'h55);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 cmd_valid", cmd_valid, 0);
    chk("R1 id_mode", id_mode, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 id_rdata", id_rdata, 8'h00);

    // R2 reset command at arbitrary address
    expect_cmd("R2 reset", 3'd0, 1'b0, '0, '0);
    bus_wr(18'h31234, 8'hF0);
    drained("R2 reset");

    // R3/R4 identify with upper address bits set
    expect_cmd("R4 ident", 3'd1, 1'b0, '0, '0);
    bus_wr(18'h3E555, 8'hAA);
    bus_wr(18'h1CAAA, 8'h55);
    bus_wr(18'h25555, 8'h90);
    drained("R3 upper bits ignored");
    chk("R4 id_mode", id_mode, 1);

    // R5 identify reads
    bus_oe_n = 1'b0;
    bus_addr = 18'h00000; #1; chk("R5 mfr", id_rdata, 8'hC2);
    bus_addr = 18'h00001; #1; chk("R5 dev", id_rdata, 8'h34);
    sect_prot = 1'b1; bus_addr = 18'h24002; #1; chk("R5 prot", id_rdata, 8'h01);
    sect_prot = 1'b0; #1; chk("R5 unprot", id_rdata, 8'h00);
    bus_addr = 18'h00003; #1; chk("R5 other", id_rdata, 8'h00);
    bus_oe_n = 1'b1;

    // R2 reset leaves identify mode
    expect_cmd("R2 reset from id", 3'd0, 1'b0, '0, '0);
    bus_wr(18'h00000, 8'hF0);
    drained("R2 reset from id");
    chk("R2 id_mode cleared", id_mode, 0);
    bus_addr = 18'h0; #1; chk("R5 idle", id_rdata, 8'h00);

    // R6 program, data F0 taken as data
    expect_cmd("R6 program", 3'd2, 1'b1, 18'h23456, 8'h5A);
    unlock2(); bus_wr(18'h00555, 8'hA0); bus_wr(18'h23456, 8'h5A);
    expect_cmd("R6 program F0", 3'd2, 1'b1, 18'h3FFFF, 8'hF0);
    unlock2(); bus_wr(18'h00555, 8'hA0); bus_wr(18'h3FFFF, 8'hF0);
    drained("R6 program");

    // R7 chip erase
    expect_cmd("R7 chip erase", 3'd3, 1'b0, '0, '0);
    unlock2(); bus_wr(18'h00555, 8'h80); unlock2(); bus_wr(18'h00555, 8'h10);
    drained("R7 chip erase");

    // R8 sector erase
    expect_cmd("R8 sector erase", 3'd4, 1'b1, 18'h18000, 8'h30);
    unlock2(); bus_wr(18'h00555, 8'h80); unlock2(); bus_wr(18'h18000, 8'h30);
    drained("R8 sector erase");

    // R9 wrong address, then rest of program sequence
    bus_wr(18'h00555, 8'hAA); bus_wr(18'h002AB, 8'h55);
    bus_wr(18'h00555, 8'hA0); bus_wr(18'h01000, 8'h77);
    // R9 wrong data
    bus_wr(18'h00555, 8'hAA); bus_wr(18'h002AA, 8'h54); bus_wr(18'h00555, 8'h90);
    drained("R9 abort");
    chk("R9 id_mode", id_mode, 0);

    // R10 suspend/resume outside erase
    bus_wr(18'h00000, 8'hB0); bus_wr(18'h00000, 8'h30);
    drained("R10 no erase");

    // R12 erase running
    ctl_erase_busy = 1'b1;
    bus_wr(18'h00555, 8'hAA); bus_wr(18'h00000, 8'hF0);
    drained("R12 ignored");
    expect_cmd("R12 suspend", 3'd5, 1'b0, '0, '0);
    bus_wr(18'h12345, 8'hB0);
    drained("R12 suspend");
    ctl_erase_busy = 1'b0; ctl_erase_susp = 1'b1;
    expect_cmd("R10 resume", 3'd6, 1'b0, '0, '0);
    bus_wr(18'h00042, 8'h30);
    drained("R10 resume");
    ctl_erase_susp = 1'b0;

    // R11 program busy
    expect_cmd("R4 ident again", 3'd1, 1'b0, '0, '0);
    unlock2(); bus_wr(18'h00555, 8'h90);
    drained("R4 ident again");
    ctl_prog_busy = 1'b1;
    bus_wr(18'h00000, 8'hF0); bus_wr(18'h00000, 8'hB0);
    drained("R11 busy ignored");
    chk("R11 mode kept", id_mode, 1);
    ctl_prog_busy = 1'b0;

    // R13 unqualified strobes
    bus_wr(18'h00000, 8'hF0, 1'b1, 1'b1);
    bus_wr(18'h00000, 8'hF0, 1'b0, 1'b0);
    drained("R13 not a write");
    chk("R13 mode kept", id_mode, 1);
    expect_cmd("R2 final reset", 3'd0, 1'b0, '0, '0);
    bus_wr(18'h00000, 8'hF0);
    drained("R2 final reset");
    chk("R2 final id_mode", id_mode, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule